// File: doc/BRIEF.md
# Duty-Cycled Receiver Wake Sequencer

This block paces the periodic wake-up of a low-power radio receiver that runs in discontinuous receive mode. Each cycle has two timed phases. A host-wake phase gives the host processor time to come out of its own low-power state. An RF-settle phase then lets the selected analog sections power up and stabilise. Both phases are counted in ticks of a fixed 120 µs time base, which an internal prescaler derives from the system clock. The receiver and the host share one open-drain handshake line. The receiver pulls this line low for both phases, and nobody driving it reads as high.

When the settle phase ends, the receiver lets go of the line. It then turns on the two demodulated data outputs and any peak detectors selected in the power configuration byte. It stays active only while the host holds the line low. If the line is seen high at any point in the active phase, the receiver powers everything down and starts a new wake cycle. A deep-sleep bit in the configuration byte overrides everything. When the discontinuous-receive enable is low, the section enables simply follow the configuration byte (continuous operation).

Top module: `rxwake_seq`

## Requirements
- R1: While reset is asserted the handshake line is released and all section and data enables are low. With the discontinuous-receive enable set and deep sleep clear, the line is driven low from the first clock edge after reset is released.
- R2: The settle length is a 16-bit count: `settle_hi` supplies bits 15..8 and `settle_lo` supplies bits 7..0.
- R3: The time base gives one tick every `TICK_DIV` clock cycles and restarts at the start of each wake cycle. A phase programmed with N lasts N+1 ticks, so a value of zero ends at the first tick.
- R4: For host-wake count W and settle count S, the line is driven low for exactly (W+1)+(S+1) ticks without a break.
- R5: During the settle phase `sect_en` equals the selected sections with both peak-detector bits (`sect_en` bits 2 and 0) forced low, and both data enables are low.
- R6: When the settle phase ends, the line is released and `sect_en` equals `pwr_cfg[7:1]` with both data enables high. A data enable is never high while the line is driven.
- R7: In the active phase, a line level seen high through the synchronizer drops every enable low and starts a new wake cycle, which drives the line low again within a few cycles.
- R8: While the host holds the line low, the active phase and its enables persist.
- R9: `pwr_cfg` bit 0 set (deep sleep) forces every section and data enable low at once, and releases the line from the next cycle on, whatever the other bits hold.
- R10: With `drx_en` low and deep sleep clear, `sect_en` equals `pwr_cfg[7:1]`, both data enables are high, and the line is never driven.
- R11: During the host-wake phase every section and data enable is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| drx_en | input | 1 | Discontinuous-receive enable |
| pwr_cfg | input | 8 | Power byte: bit i (7..1) selects a section, mapped to `sect_en[i-1]`; bit 0 selects deep sleep |
| settle_hi | input | 8 | Upper byte of the settle tick count |
| settle_lo | input | 8 | Lower byte of the settle tick count |
| wake_ticks | input | WAKE_W | Host-wake tick count, loaded at the start of each cycle |
| hs_line | input | 1 | Sensed level of the shared handshake line |
| hs_drive_low | output | 1 | 1 pulls the handshake line low |
| sect_en | output | 7 | Section enables: 6 LNA, 5 AGC, 4 mixer, 3 FSK baseband, 2 FSK peak detect, 1 ASK baseband, 0 ASK peak detect |
| ask_data_en | output | 1 | ASK data output enable |
| fsk_data_en | output | 1 | FSK data output enable |

## Verification
The bench builds the block with `TICK_DIV` = 4 and a two-stage line synchronizer. With these values one tick is four clocks, so the exact drive-low length can be counted cycle by cycle. A settle count of 258 then spans about a thousand cycles, which makes a swapped byte order clearly visible. The short synchronizer keeps the restart after a host that never takes the line within a small observation window. The zero-count cases show the advance on the first tick.

// File: rtl/rxwake_pkg.sv
package rxwake_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAKE   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_ACTIVE = 2'd3
  } seq_state_t;

  localparam int CFG_W     = 8;
  localparam int SECT_W    = CFG_W - 1;
  localparam int CFG_SLEEP = 0;
  localparam int SETTLE_W  = 16;

  // peak detector positions inside sect_en (ASK at 0, FSK at 2)
  localparam logic [SECT_W-1:0] PD_MASK = 7'b000_0101;

endpackage

// File: rtl/rxwake_tick.sv
module rxwake_tick #(
  parameter int TICK_DIV = 15000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic             pre_en;

  assign tick = run && (pre_q == PRE_LAST);

  always_comb begin
    pre_en = 1'b1;
    if (!run)      pre_d = '0;
    else if (tick) pre_d = '0;
    else           pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  p_pre_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pre_q) < TICK_DIV);

  generate
    if (TICK_DIV > 1) begin : g_gap
      p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/rxwake_sync.sv
module rxwake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= {sh_q[STAGES-2:0], d};
      end
    end else begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= d;
      end
    end
  endgenerate

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/rxwake_pwr.sv
module rxwake_pwr
  import rxwake_pkg::*;
(
  input  seq_state_t        state,
  input  logic              drx_en,
  input  logic [CFG_W-1:0]  pwr_cfg,
  output logic [SECT_W-1:0] sect_en,
  output logic              ask_data_en,
  output logic              fsk_data_en
);
  logic [SECT_W-1:0] sel;
  logic              sleep;

  assign sel   = pwr_cfg[CFG_W-1:1];
  assign sleep = pwr_cfg[CFG_SLEEP];

  always_comb begin
    sect_en     = '0;
    ask_data_en = 1'b0;
    fsk_data_en = 1'b0;
    if (sleep) begin
      sect_en = '0;
    end else if (!drx_en) begin
      sect_en     = sel;
      ask_data_en = 1'b1;
      fsk_data_en = 1'b1;
    end else begin
      unique case (state)
        ST_SETTLE: sect_en = sel & ~PD_MASK;
        ST_ACTIVE: begin
          sect_en     = sel;
          ask_data_en = 1'b1;
          fsk_data_en = 1'b1;
        end
        default:   sect_en = '0;
      endcase
    end
  end

endmodule

// File: rtl/rxwake_fsm.sv
module rxwake_fsm
  import rxwake_pkg::*;
#(
  parameter int WAKE_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                drx_en,
  input  logic                sleep,
  input  logic                tick,
  input  logic                line_hi,
  input  logic [WAKE_W-1:0]   wake_ticks,
  input  logic [SETTLE_W-1:0] settle_val,
  output seq_state_t          state,
  output logic                run,
  output logic                hs_drive_low
);
  localparam int CNT_W = (WAKE_W > SETTLE_W) ? WAKE_W : SETTLE_W;

  seq_state_t       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             go_idle;
  logic             cnt_zero;

  assign go_idle  = sleep || !drx_en;
  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (go_idle) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          state_d = ST_WAKE;
          cnt_d   = CNT_W'(wake_ticks);
          cnt_en  = 1'b1;
        end
        ST_WAKE: begin
          if (tick) begin
            cnt_en = 1'b1;
            if (cnt_zero) begin
              state_d = ST_SETTLE;
              cnt_d   = CNT_W'(settle_val);
            end else begin
              cnt_d = cnt_q - CNT_W'(1);
            end
          end
        end
        ST_SETTLE: begin
          if (tick) begin
            cnt_en = 1'b1;
            if (cnt_zero) state_d = ST_ACTIVE;
            else          cnt_d   = cnt_q - CNT_W'(1);
          end
        end
        ST_ACTIVE: begin
          if (line_hi) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign state        = state_q;
  assign run          = (state_q != ST_IDLE);
  assign hs_drive_low = (state_q == ST_WAKE) || (state_q == ST_SETTLE);

  p_settle_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAKE && tick && cnt_zero && drx_en && !sleep)
    |=> (state_q == ST_SETTLE && cnt_q == CNT_W'($past(settle_val))));

  p_zero_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SETTLE && tick && cnt_zero && drx_en && !sleep)
    |=> state_q == ST_ACTIVE);

  p_hold_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_drive_low && !tick && drx_en && !sleep) |=> $stable(cnt_q) && $stable(state_q));

  p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && line_hi) |=> state_q == ST_IDLE);

  p_stay_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ACTIVE && !line_hi && drx_en && !sleep) |=> state_q == ST_ACTIVE);

endmodule

// File: rtl/rxwake_seq.sv
module rxwake_seq
  import rxwake_pkg::*;
#(
  parameter int TICK_DIV    = 15000,
  parameter int WAKE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drx_en,
  input  logic [7:0]        pwr_cfg,
  input  logic [7:0]        settle_hi,
  input  logic [7:0]        settle_lo,
  input  logic [WAKE_W-1:0] wake_ticks,
  input  logic              hs_line,
  output logic              hs_drive_low,
  output logic [6:0]        sect_en,
  output logic              ask_data_en,
  output logic              fsk_data_en
);
  seq_state_t          state;
  logic                run;
  logic                tick;
  logic                line_hi;
  logic [SETTLE_W-1:0] settle_val;

  assign settle_val = {settle_hi, settle_lo};

  rxwake_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .tick (tick)
  );

  rxwake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (hs_line),
    .q    (line_hi)
  );

  rxwake_fsm #(.WAKE_W(WAKE_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .drx_en      (drx_en),
    .sleep       (pwr_cfg[CFG_SLEEP]),
    .tick        (tick),
    .line_hi     (line_hi),
    .wake_ticks  (wake_ticks),
    .settle_val  (settle_val),
    .state       (state),
    .run         (run),
    .hs_drive_low(hs_drive_low)
  );

  rxwake_pwr u_pwr (
    .state      (state),
    .drx_en     (drx_en),
    .pwr_cfg    (pwr_cfg),
    .sect_en    (sect_en),
    .ask_data_en(ask_data_en),
    .fsk_data_en(fsk_data_en)
  );

  p_no_data_while_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hs_drive_low |-> (!ask_data_en && !fsk_data_en && (sect_en & PD_MASK) == '0));

  p_sleep_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cfg[CFG_SLEEP] |=> !hs_drive_low);

  p_sleep_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_cfg[CFG_SLEEP] |-> (sect_en == '0 && !ask_data_en && !fsk_data_en));

  p_continuous_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!drx_en && !pwr_cfg[CFG_SLEEP]) |=> !hs_drive_low);

endmodule

// File: tb/rxwake_seq_tb.sv
module rxwake_seq_tb;
  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        drx_en;
  logic [7:0]  pwr_cfg;
  logic [7:0]  settle_hi, settle_lo;
  logic [15:0] wake_ticks;
  logic        host_low;
  logic        hs_line;
  logic        hs_drive_low;
  logic [6:0]  sect_en;
  logic        ask_data_en, fsk_data_en;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  assign hs_line = !(hs_drive_low || host_low);

  rxwake_seq #(.TICK_DIV(P), .WAKE_W(16), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .drx_en(drx_en), .pwr_cfg(pwr_cfg),
    .settle_hi(settle_hi), .settle_lo(settle_lo), .wake_ticks(wake_ticks),
    .hs_line(hs_line), .hs_drive_low(hs_drive_low), .sect_en(sect_en),
    .ask_data_en(ask_data_en), .fsk_data_en(fsk_data_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int outs();
    return {23'd0, sect_en, ask_data_en, fsk_data_en};
  endfunction

  task automatic park();
    @(negedge clk);
    pwr_cfg  = 8'h01;
    drx_en   = 1'b1;
    host_low = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // R1, R11: reset state and first cycle start
  task automatic t_reset();
    rst_n = 1'b0; drx_en = 1'b1; pwr_cfg = 8'hFE; host_low = 1'b0;
    settle_hi = 8'd0; settle_lo = 8'd0; wake_ticks = 16'd2;
    repeat (3) @(negedge clk);
    chk(!hs_drive_low, "R1 line released in reset", int'(hs_drive_low), 0);
    chk(outs() == 0, "R1 enables low in reset", outs(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hs_drive_low, "R1 drive after reset", int'(hs_drive_low), 1);
    chk(outs() == 0, "R11 enables off in host wake", outs(), 0);
  endtask

  task automatic run_cycle(input int w, input int s, input logic [7:0] cfg,
                           input bit host_takes);
    int n_drv = 0, n_set = 0, bad = 0, n_act = 0, k;
    logic [6:0] exp_set, exp_act;
    exp_act = cfg[7:1];
    exp_set = cfg[7:1] & ~7'b000_0101;
    park();
    wake_ticks = 16'(w);
    settle_hi  = 8'(s >> 8);
    settle_lo  = 8'(s);
    pwr_cfg    = {cfg[7:1], 1'b0};
    @(negedge clk);
    k = 0;
    while (hs_drive_low && k < 5000) begin
      n_drv++;
      if (sect_en == exp_set && exp_set != 0) begin
        n_set++;
        if (host_takes) host_low = 1'b1;
      end else if (sect_en != 0) bad++;
      if (ask_data_en || fsk_data_en) bad++;
      k++;
      @(negedge clk);
    end
    chk(n_drv == (w + s + 2) * P, "R4 R2 drive-low length", n_drv, (w + s + 2) * P);
    chk(n_set == (s + 1) * P, "R5 R3 settle length", n_set, (s + 1) * P);
    chk(bad == 0, "R5 R11 phase enables", bad, 0);
    chk(sect_en == exp_act && ask_data_en && fsk_data_en, "R6 active enables",
        outs(), {23'd0, exp_act, 2'b11});
    if (host_takes) begin
      for (int i = 0; i < 30; i++) begin
        if (hs_drive_low || sect_en != exp_act || !ask_data_en) n_act++;
        @(negedge clk);
      end
      chk(n_act == 0, "R8 active held by host", n_act, 0);
      host_low = 1'b0;
    end
    k = 0;
    while (!hs_drive_low && k < 8) begin
      k++;
      @(negedge clk);
    end
    chk(hs_drive_low, "R7 restart after line high", int'(hs_drive_low), 1);
    chk(outs() == 0, "R7 enables dropped on restart", outs(), 0);
  endtask

  // R9: deep sleep overrides an active receiver
  task automatic t_sleep();
    int k = 0, bad = 0;
    park();
    wake_ticks = 16'd1; settle_hi = 8'd0; settle_lo = 8'd1;
    host_low = 1'b1;
    pwr_cfg = 8'hFE;
    @(negedge clk);
    while (hs_drive_low && k < 200) begin k++; @(negedge clk); end
    chk(ask_data_en && sect_en == 7'h7F, "R9 precondition active", outs(), 511);
    pwr_cfg = 8'hFF;
    #1;
    chk(outs() == 0, "R9 enables dark at once", outs(), 0);
    host_low = 1'b0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (hs_drive_low || outs() != 0) bad++;
    end
    chk(bad == 0, "R9 held idle in sleep", bad, 0);
  endtask

  // R10: continuous operation when discontinuous mode is off
  task automatic t_continuous();
    int bad = 0;
    park();
    drx_en = 1'b0;
    pwr_cfg = 8'hAA;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (hs_drive_low || sect_en != 7'h55 || !ask_data_en || !fsk_data_en) bad++;
    end
    chk(bad == 0, "R10 continuous follows config", bad, 0);
    chk(sect_en == 7'h55, "R10 section map", int'(sect_en), 85);
    drx_en = 1'b1;
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    run_cycle(2, 3, 8'hFE, 1'b1);
    run_cycle(0, 0, 8'hFE, 1'b0);
    run_cycle(3, 258, 8'hA4, 1'b1);
    run_cycle(1, 2, 8'h5A, 1'b0);
    t_sleep();
    t_continuous();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule